// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo serial audio stream into parallel samples. The stream has a bit clock, a frame clock and a data line. The block is always a slave to both clocks. A faster system clock oversamples the three lines and finds the rising edges of the bit clock. On each edge it takes one data bit and one frame-clock level.

A 3-bit format code selects how words sit inside each channel half of the frame. Three framings are supported: left-justified, I2S, and right-justified with 16, 18, 20 or 24 bits. At the end of every frame the block presents one 24-bit left word and one 24-bit right word. Both are MSB-aligned, with zeros below a shorter word. A one-cycle valid pulse marks them. Bit-clock to frame-clock ratios of 32, 48, 64, 96 and 128 are accepted.

A state machine tracks frame alignment. It has four states:
- `ST_IDLE` waits for the first bit-clock edge, and the machine stays here while the code is reserved.
- `ST_SEEK` waits for the start of a left word.
- `ST_LEFT` collects the left word.
- `ST_RIGHT` collects the right word.

The transitions are:
- `ST_IDLE` goes to `ST_SEEK` on any bit edge when the format code is usable.
- `ST_SEEK` goes to `ST_LEFT` when a left slot begins.
- `ST_LEFT` goes to `ST_RIGHT` when the right slot begins, and the left word is held at that point.
- `ST_RIGHT` goes to `ST_LEFT` when the next left slot begins. The frame is published at that point.
- Reset, a change of format code and a reserved code all force `ST_IDLE` from any state.

Top module: `aud_rx_deser`

## Requirements
- R1: After reset `word_vld` is 0, and `left_word` and `right_word` are 0.
- R2: Data and frame-clock levels are taken on the rising edge of `bit_clk`. The bench changes them on the falling edge. For codes other than 001, a high `frm_clk` marks the left channel.
- R3: Code 000 (left-justified) takes the MSB on the first bit-clock rise of a channel slot. It takes up to 24 bits, or fewer when the slot is shorter.
- R4: Code 001 (I2S) treats a low `frm_clk` as the left channel. The MSB comes on the second bit-clock rise after a frame-clock transition. Up to 24 bits are taken, and the last bit may fall on the first rise of the following slot.
- R5: Codes 010, 011, 100 and 101 are right-justified with widths of 16, 24, 20 and 18 bits respectively. The word is the last W bits of the slot before the next frame-clock transition. Earlier bits in the slot are ignored.
- R6: A word shorter than 24 bits appears in bits 23 down to 24-W of the output. Every bit below it reads 0, even when the line carries other bits there.
- R7: `word_vld` is high for exactly one system cycle per frame. It rises on the third system clock after the bit-clock rise that starts the next left word. `left_word` and `right_word` change only in that cycle.
- R8: Frames with 32, 48, 64, 96 and 128 bit clocks per frame are received correctly. For right-justified codes the slot must be at least W bits long.
- R9: Codes 110 and 111 are reserved. While either is applied, `word_vld` stays 0.
- R10: After reset or any change of the format code, no frame is published until a complete left slot and a complete right slot have both been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `bit_clk` |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Framing format code |
| bit_clk | input | 1 | Serial bit clock from the external master |
| frm_clk | input | 1 | Frame (channel select) clock from the external master |
| ser_dat | input | 1 | Serial audio data |
| left_word | output | 24 | Left-channel word, MSB-aligned |
| right_word | output | 24 | Right-channel word, MSB-aligned |
| word_vld | output | 1 | One-cycle pulse when a complete frame is presented |

## Verification
A bit-clock rise reaches the decision logic after two synchronizer flops. The output registers update one clock later. So the valid pulse and the new words are due on the third system clock after the bench raises `bit_clk` for the bit that opens the next left word. For left-justified and right-justified codes that is bit 0 of the next frame; for I2S it is bit 1. The bench holds each bit-clock phase for four system cycles and samples at every falling system edge. It demands the pulse at exactly the third sample of that high phase and a low `word_vld` at every other sample. It sweeps each usable format across all five ratios; right-justified widths longer than the slot are skipped. The expected words come from pseudo-random values masked to the transmitted width, and filler bits outside the word test that those bits are ignored.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int WORD_W = 24;

    typedef enum logic [2:0] {
        FMT_LJ   = 3'b000,
        FMT_I2S  = 3'b001,
        FMT_RJ16 = 3'b010,
        FMT_RJ24 = 3'b011,
        FMT_RJ20 = 3'b100,
        FMT_RJ18 = 3'b101,
        FMT_RSV6 = 3'b110,
        FMT_RSV7 = 3'b111
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    function automatic logic fmt_reserved(input logic [2:0] f);
        return f[2] & f[1];
    endfunction

    function automatic logic fmt_right_just(input logic [2:0] f);
        return (f >= 3'd2) && (f <= 3'd5);
    endfunction

    function automatic int unsigned rj_width(input logic [2:0] f);
        unique case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            FMT_RJ18: return 18;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    input  logic frm_clk,
    input  logic ser_dat,
    output logic bit_stb,
    output logic frm_smp,
    output logic dat_smp
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] b_sh;
    logic [SYNC_STAGES-1:0] f_sh;
    logic [SYNC_STAGES-1:0] d_sh;
    logic                   b_last;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    b_sh <= '0;
                    f_sh <= '0;
                    d_sh <= '0;
                end else begin
                    b_sh <= bit_clk;
                    f_sh <= frm_clk;
                    d_sh <= ser_dat;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    b_sh <= '0;
                    f_sh <= '0;
                    d_sh <= '0;
                end else begin
                    b_sh <= {b_sh[SYNC_STAGES-2:0], bit_clk};
                    f_sh <= {f_sh[SYNC_STAGES-2:0], frm_clk};
                    d_sh <= {d_sh[SYNC_STAGES-2:0], ser_dat};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) b_last <= 1'b0;
        else        b_last <= b_sh[TOP];
    end

    assign bit_stb = b_sh[TOP] & ~b_last;
    assign frm_smp = f_sh[TOP];
    assign dat_smp = d_sh[TOP];

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R2

endmodule

// File: rtl/aud_rx_phase.sv
module aud_rx_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic frm_smp,
    input  logic fmt_i2s,
    output logic left_now,
    output logic slot_edge
);

    logic f_prev;
    logic left_prev;
    logic eff_lvl;

    // I2S is seen through a frame clock delayed by one bit and inverted,
    // which turns it into the left-justified case.
    always_comb begin
        eff_lvl   = fmt_i2s ? f_prev : frm_smp;
        left_now  = fmt_i2s ? ~eff_lvl : eff_lvl;
        slot_edge = left_now ^ left_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_prev    <= 1'b0;
            left_prev <= 1'b0;
        end else if (bit_stb) begin
            f_prev    <= frm_smp;
            left_prev <= left_now;
        end
    end

endmodule

// File: rtl/aud_rx_accum.sv
module aud_rx_accum
    import aud_rx_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              dat_smp,
    input  logic              slot_edge,
    input  logic [2:0]        fmt,
    output logic [WORD_W-1:0] word_aligned
);

    localparam int POS_W = $clog2(WORD_W);

    logic [WORD_W-1:0] acc;
    logic [IDX_W-1:0]  idx;
    logic [POS_W-1:0]  pos;
    logic              positional;

    assign positional = !fmt_right_just(fmt);
    assign pos        = POS_W'(WORD_W - 1) - idx[POS_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (bit_stb) begin
            if (slot_edge) begin
                idx <= IDX_W'(1);
                if (positional) acc <= {dat_smp, {(WORD_W-1){1'b0}}};
                else            acc <= {{(WORD_W-1){1'b0}}, dat_smp};
            end else begin
                if (idx != {IDX_W{1'b1}}) idx <= idx + IDX_W'(1);
                if (positional) begin
                    if (idx < IDX_W'(WORD_W)) acc[pos] <= dat_smp;
                end else begin
                    acc <= {acc[WORD_W-2:0], dat_smp};
                end
            end
        end
    end

    always_comb begin
        if (positional) word_aligned = acc;
        else            word_aligned = acc << (WORD_W - rj_width(fmt));
    end

    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && slot_edge) |=> (idx == IDX_W'(1))); // R3

endmodule

// File: rtl/aud_rx_fsm.sv
module aud_rx_fsm
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              left_now,
    input  logic              slot_edge,
    input  logic              fmt_chg,
    input  logic              fmt_rsv,
    input  logic [2:0]        fmt,
    input  logic [WORD_W-1:0] word_aligned,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_vld
);

    rx_state_e         state;
    rx_state_e         nxt;
    logic [WORD_W-1:0] left_hold;
    logic              usable;
    logic              enter_left;
    logic              enter_right;
    logic              take_left;
    logic              take_frame;

    assign usable      = !fmt_chg && !fmt_rsv;
    assign enter_left  = bit_stb && slot_edge && left_now;
    assign enter_right = bit_stb && slot_edge && !left_now;
    assign take_left   = usable && enter_right && (state == ST_LEFT);
    assign take_frame  = usable && enter_left && (state == ST_RIGHT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (bit_stb)     nxt = ST_SEEK;
            ST_SEEK:  if (enter_left)  nxt = ST_LEFT;
            ST_LEFT:  if (enter_right) nxt = ST_RIGHT;
            ST_RIGHT: if (enter_left)  nxt = ST_LEFT;
        endcase
        if (!usable) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold  <= '0;
            left_word  <= '0;
            right_word <= '0;
            word_vld   <= 1'b0;
        end else begin
            word_vld <= take_frame;
            if (take_left) left_hold <= word_aligned;
            if (take_frame) begin
                left_word  <= left_hold;
                right_word <= word_aligned;
            end
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> ($stable(left_word) && $stable(right_word))); // R7
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_rsv |=> !word_vld); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !word_vld); // R10
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && fmt == FMT_RJ16) |-> (left_word[7:0] == 8'h0 && right_word[7:0] == 8'h0)); // R6

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_RATIO   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_sel,
    input  logic              bit_clk,
    input  logic              frm_clk,
    input  logic              ser_dat,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_vld
);

    localparam int IDX_W = $clog2(MAX_RATIO);

    logic [2:0]        fmt_q;
    logic              fmt_chg;
    logic              fmt_rsv;
    logic              fmt_i2s;
    logic              bit_stb;
    logic              frm_smp;
    logic              dat_smp;
    logic              left_now;
    logic              slot_edge;
    logic [WORD_W-1:0] word_aligned;

    always_ff @(posedge clk) begin
        if (!rst_n) fmt_q <= FMT_LJ;
        else        fmt_q <= fmt_sel;
    end

    assign fmt_chg = (fmt_sel != fmt_q);
    assign fmt_rsv = fmt_reserved(fmt_q);
    assign fmt_i2s = (fmt_q == FMT_I2S);

    aud_rx_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_clk (bit_clk),
        .frm_clk (frm_clk),
        .ser_dat (ser_dat),
        .bit_stb (bit_stb),
        .frm_smp (frm_smp),
        .dat_smp (dat_smp)
    );

    aud_rx_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .frm_smp   (frm_smp),
        .fmt_i2s   (fmt_i2s),
        .left_now  (left_now),
        .slot_edge (slot_edge)
    );

    aud_rx_accum #(
        .IDX_W(IDX_W)
    ) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .dat_smp      (dat_smp),
        .slot_edge    (slot_edge),
        .fmt          (fmt_q),
        .word_aligned (word_aligned)
    );

    aud_rx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .left_now     (left_now),
        .slot_edge    (slot_edge),
        .fmt_chg      (fmt_chg),
        .fmt_rsv      (fmt_rsv),
        .fmt          (fmt_q),
        .word_aligned (word_aligned),
        .left_word    (left_word),
        .right_word   (right_word),
        .word_vld     (word_vld)
    );

endmodule

// File: tb/aud_rx_deser_tb.sv
module aud_rx_deser_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'b000;
    logic        bit_clk = 1'b0;
    logic        frm_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [23:0] left_word;
    logic [23:0] right_word;
    logic        word_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [23:0] wl [0:3];
    logic [23:0] wr [0:3];
    logic [23:0] g_mask;
    logic [31:0] seed = 32'h1234_5678;
    int g_fmt, g_ratio, g_half, g_n, g_sl;

    always #10 clk = ~clk;

    aud_rx_deser u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .bit_clk    (bit_clk),
        .frm_clk    (frm_clk),
        .ser_dat    (ser_dat),
        .left_word  (left_word),
        .right_word (right_word),
        .word_vld   (word_vld)
    );

    task automatic check(input bit ok, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s fmt=%0d ratio=%0d act=%h exp=%h", what, g_fmt, g_ratio, act, exp);
        end
    endtask

    function automatic logic line_bit(input int f, input int p);
        int k;
        k = p - g_sl;
        if (k >= 0 && k < g_n) return wl[f][23-k];
        k = p - (g_sl + g_half);
        if (k >= 0 && k < g_n) return wr[f][23-k];
        if (f >= 1) begin
            k = p - (g_sl + g_half - g_ratio);
            if (k >= 0 && k < g_n) return wr[f-1][23-k];
        end
        return logic'(((p ^ (p >> 2) ^ f) & 1) != 0);
    endfunction

    task automatic send_bit(input logic fv, input logic dv, input bit due, input int fi, input string tag);
        logic [23:0] el, er;
        string rq;
        rq = (g_fmt == 0) ? "R3" : (g_fmt == 1) ? "R4" : "R5";
        bit_clk = 1'b0;
        frm_clk = fv;
        ser_dat = dv;
        repeat (4) begin
            @(negedge clk);
            check(word_vld == 1'b0, {tag, " no pulse in low phase"}, {23'b0, word_vld}, 24'h0);
        end
        bit_clk = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (due && i == 3) begin
                el = wl[fi] & g_mask;
                er = wr[fi] & g_mask;
                check(word_vld == 1'b1, "R7 pulse on 3rd cycle", {23'b0, word_vld}, 24'h1);
                check(left_word == el, {rq, " R2 R8 left word"}, left_word, el);
                check(right_word == er, {rq, " R2 R8 right word"}, right_word, er);
                check((left_word & ~g_mask) == 24'h0 && (right_word & ~g_mask) == 24'h0,
                      "R6 zero fill", left_word | right_word, 24'h0);
            end else begin
                check(word_vld == 1'b0, {tag, " pulse only when due"}, {23'b0, word_vld}, 24'h0);
            end
        end
    endtask

    task automatic run_cfg(input int fmt, input int ratio, input int nfr);
        int w;
        int vpos;
        bit rsv, i2s, left;
        string tag;
        rsv = (fmt >= 6);
        i2s = (fmt == 1);
        g_fmt = fmt;
        g_ratio = ratio;
        g_half = ratio / 2;
        fmt_sel = 3'(fmt);
        w = (fmt == 2) ? 16 : (fmt == 3) ? 24 : (fmt == 4) ? 20 : (fmt == 5) ? 18 : 0;
        if (w == 0) begin
            g_n = (g_half < 24) ? g_half : 24;
            g_sl = i2s ? 1 : 0;
        end else begin
            g_n = w;
            g_sl = g_half - w;
        end
        vpos = i2s ? 1 : 0;
        g_mask = 24'hFF_FFFF << (24 - g_n);
        for (int f = 0; f <= nfr; f++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            wl[f] = seed[31:8];
            seed = seed * 32'd1664525 + 32'd1013904223;
            wr[f] = seed[31:8];
        end
        // preamble: frame clock parked at the right-channel level
        repeat (4) send_bit(i2s, 1'b0, 1'b0, 0, rsv ? "R9" : "R10");
        for (int f = 0; f <= nfr; f++) begin
            for (int p = 0; p < ratio; p++) begin
                left = (p < g_half);
                if (rsv) tag = "R9";
                else if (f == 0 && p == vpos) tag = "R10";
                else tag = "R7";
                send_bit(i2s ? !left : left, line_bit(f, p),
                         !rsv && f >= 1 && p == vpos, f - 1, tag);
            end
        end
    endtask

    initial begin
        int ratios [5];
        int w;
        ratios = '{32, 48, 64, 96, 128};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_vld == 1'b0, "R1 reset valid", {23'b0, word_vld}, 24'h0);
        check(left_word == 24'h0, "R1 reset left", left_word, 24'h0);
        check(right_word == 24'h0, "R1 reset right", right_word, 24'h0);
        foreach (ratios[r]) begin
            for (int fmt = 0; fmt <= 5; fmt++) begin
                w = (fmt == 2) ? 16 : (fmt == 3) ? 24 : (fmt == 4) ? 20 : (fmt == 5) ? 18 : 0;
                if (w <= ratios[r] / 2) run_cfg(fmt, ratios[r], 3);
            end
        end
        run_cfg(6, 64, 2);
        run_cfg(7, 64, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule